// File: doc/BRIEF.md
# Dual Interval Timer With Shared Interrupt Line

This block puts two identical down-counting interval timers behind one 4 KB register window. Each timer takes up a 32-byte slot. The first slot starts at byte 0 and the second at byte 0x20. The decoder removes the slot base from the address before the selected timer sees it. Every address at 0x40 and above reads as zero, and writes to those addresses do nothing. The two timers share one tick-enable input, which is nominally a 1 MHz strobe. Each timer divides that tick on its own by 1, 16 or 256.

Each timer holds its own sticky interrupt flag and its own enable mask. The block has one interrupt output, which is the OR of the two masked flags. Software clears the flag of the timer it is servicing. The shared line stays high as long as the other timer still has a pending, enabled interrupt. Read data comes back combinationally in the same cycle as the access, and writes take effect at the next clock edge.

Top module: `dual_timer`

## Requirements
- R1: After reset, each timer's control register reads 0x40 (interrupt enable set, everything else clear). Reload, count and both status registers read 0, and `irq_o` is low.
- R2: Byte address 0x00..0x1F selects timer 0 and 0x20..0x3F selects timer 1, with bits [4:2] picking the register and bits [1:0] ignored. Addresses 0x40..0xFFF read 0 and writes to them change no timer.
- R3: Per-timer register offsets are: 0x00 control (read/write), 0x04 reload, 0x08 background reload, 0x0C count (read-only, writes ignored), 0x10 interrupt clear (write), 0x14 raw flag in bit 0, 0x18 masked flag in bit 0, 0x1C reads 0.
- R4: Control bit fields are: bit 0 run, bit 1 periodic, bit 2 one-shot, bit 3 32-bit width (0 = 16-bit), bits [5:4] prescale code, bit 6 interrupt enable.
- R5: While run is set, the count falls by one on each prescaled tick. A prescaled tick occurs every 1, 16 or 256 `tick_i` pulses for code 0, 1 or 2, and code 3 acts as 1. After a control write that sets run with count L, the raw flag rises (L+1)*N clock edges later when `tick_i` is held high. With `tick_i` low the count holds.
- R6: In periodic mode, a prescaled tick at count 0 sets the raw flag and reloads the count from the reload register.
- R7: In free-running mode (periodic and one-shot both clear), a prescaled tick at count 0 sets the raw flag and reloads the count with 0xFFFF in 16-bit width or 0xFFFFFFFF in 32-bit width.
- R8: In one-shot mode, which overrides periodic, a prescaled tick at count 0 sets the raw flag, leaves the count at 0 and clears the run bit.
- R9: A write to the reload register stores the full word and loads the count with it. In 16-bit width the loaded count is masked to its low 16 bits.
- R10: The raw flag stays set until an interrupt clear write. If a set and a clear land in the same cycle, the set wins. The masked flag is the raw flag ANDed with interrupt enable.
- R11: `irq_o` is the OR of both timers' masked flags. Clearing one timer's flag leaves `irq_o` high while the other timer's masked flag is set.
- R12: A write to the background reload register changes only the reload value. The current count is untouched, and the new value is used at the next reload.
- R13: Any control write restarts the selected timer's prescaler phase from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Shared tick enable, one cycle per tick |
| sel_i | input | 1 | Access strobe |
| wr_i | input | 1 | Write when high, read when low |
| addr_i | input | 12 | Byte address inside the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is the exact edge at which a divided tick meets a zero count. That edge depends on the prescaler phase, which no register exposes. The stimulus restarts the phase with a control write, holds `tick_i` high and polls the raw flag on every cycle, across all four prescale codes and several reload values on both slots. A separate sequence rewrites the control register part-way through a divide-by-16 period, which shows that the phase really restarts. The merged line is driven into the state where both flags are pending, and the two flags are then cleared one at a time.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;
  localparam int unsigned DATA_W = 32;

  // word index inside a 32-byte timer slot
  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_RELOAD = 3'd1,
    REG_BGRLD  = 3'd2,
    REG_COUNT  = 3'd3,
    REG_ACK    = 3'd4,
    REG_RAW    = 3'd5,
    REG_MASKED = 3'd6,
    REG_NONE   = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic       irq_en;    // bit 6
    logic [1:0] pre;       // bits 5:4
    logic       wide;      // bit 3
    logic       oneshot;   // bit 2
    logic       periodic;  // bit 1
    logic       run;       // bit 0
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
  localparam ctrl_t CTRL_RST = '{irq_en: 1'b1, pre: 2'b00, wide: 1'b0,
                                 oneshot: 1'b0, periodic: 1'b0, run: 1'b0};
endpackage

// File: rtl/dt_prescale.sv
module dt_prescale #(
  parameter int unsigned MID_LOG2 = 4,
  parameter int unsigned HI_LOG2  = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic       run_i,
  input  logic       tick_i,
  input  logic [1:0] div_sel_i,
  output logic       step_o
);
  localparam int unsigned PRE_W = HI_LOG2;
  localparam logic [PRE_W-1:0] LIM_MID = PRE_W'((1 << MID_LOG2) - 1);
  localparam logic [PRE_W-1:0] LIM_HI  = PRE_W'((1 << HI_LOG2) - 1);

  logic [PRE_W-1:0] cnt_q, lim;

  always_comb begin
    unique case (div_sel_i)
      2'd1:    lim = LIM_MID;
      2'd2:    lim = LIM_HI;
      default: lim = '0;
    endcase
  end

  assign step_o = run_i & tick_i & (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (restart_i)       cnt_q <= '0;
    else if (run_i && tick_i) cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/dt_timer_core.sv
module dt_timer_core
  import dual_timer_pkg::*;
#(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned NARROW_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  reg_sel_e          rsel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam logic [CNT_W-1:0] NARROW_MASK = CNT_W'((64'd1 << NARROW_W) - 1);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q, count_q, wmask;
  logic             raw_q, step, at_zero;
  logic             wr_ctrl, wr_reload, wr_bg, wr_ack;

  assign wr_ctrl   = wr_i && (rsel_i == REG_CTRL);
  assign wr_reload = wr_i && (rsel_i == REG_RELOAD);
  assign wr_bg     = wr_i && (rsel_i == REG_BGRLD);
  assign wr_ack    = wr_i && (rsel_i == REG_ACK);
  assign wmask     = ctrl_q.wide ? '1 : NARROW_MASK;

  dt_prescale u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (wr_ctrl),
    .run_i     (ctrl_q.run),
    .tick_i    (tick_i),
    .div_sel_i (ctrl_q.pre),
    .step_o    (step)
  );

  assign at_zero = step && (count_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
    end else if (wr_ctrl) begin
      ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
    end else if (at_zero && ctrl_q.oneshot) begin
      ctrl_q.run <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 reload_q <= '0;
    else if (wr_reload || wr_bg) reload_q <= CNT_W'(wdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
    end else if (wr_reload) begin
      count_q <= CNT_W'(wdata_i) & wmask;
    end else if (step) begin
      if (count_q != '0)         count_q <= count_q - 1'b1;
      else if (ctrl_q.oneshot)   count_q <= '0;
      else if (ctrl_q.periodic)  count_q <= reload_q & wmask;
      else                       count_q <= wmask;
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      raw_q <= 1'b0;
    else if (at_zero) raw_q <= 1'b1;
    else if (wr_ack)  raw_q <= 1'b0;
  end

  assign irq_o = raw_q & ctrl_q.irq_en;

  always_comb begin
    unique case (rsel_i)
      REG_CTRL:              rdata_o = DATA_W'(ctrl_q);
      REG_RELOAD, REG_BGRLD: rdata_o = DATA_W'(reload_q);
      REG_COUNT:             rdata_o = DATA_W'(count_q);
      REG_RAW:               rdata_o = DATA_W'(raw_q);
      REG_MASKED:            rdata_o = DATA_W'(irq_o);
      default:               rdata_o = '0;
    endcase
  end

  // R5
  count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && count_q != '0 && !wr_i) |=> (count_q == $past(count_q) - 1'b1));

  // R8
  oneshot_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_zero && ctrl_q.oneshot && !wr_i) |=> (!ctrl_q.run && count_q == '0));

  // R10
  raw_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_q && !wr_ack) |=> raw_q);
endmodule

// File: rtl/dt_addr_dec.sv
module dt_addr_dec
  import dual_timer_pkg::*;
#(
  parameter int unsigned NUM_TMR = 2,
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned SLOT_AW = 5,
  localparam int unsigned IDX_W  = ADDR_W - SLOT_AW
) (
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_TMR-1:0] tmr_wr_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              hit_o,
  output reg_sel_e          rsel_o
);
  logic unused_lsb;
  assign unused_lsb = ^addr_i[1:0];

  assign idx_o  = addr_i[ADDR_W-1:SLOT_AW];
  assign hit_o  = idx_o < IDX_W'(NUM_TMR);
  assign rsel_o = reg_sel_e'(addr_i[SLOT_AW-1:2]);

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_wr
    assign tmr_wr_o[g] = sel_i && wr_i && hit_o && (idx_o == IDX_W'(g));
  end
endmodule

// File: rtl/dual_timer.sv
module dual_timer
  import dual_timer_pkg::*;
#(
  parameter int unsigned NUM_TMR  = 2,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned SLOT_AW  = 5,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned NARROW_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned IDX_W    = ADDR_W - SLOT_AW;
  localparam int unsigned WIN_TOP  = NUM_TMR << SLOT_AW;

  logic [NUM_TMR-1:0] tmr_wr, tmr_irq;
  logic [IDX_W-1:0]   idx;
  logic               hit;
  reg_sel_e           rsel;
  logic [DATA_W-1:0]  tmr_rd [NUM_TMR];

  dt_addr_dec #(
    .NUM_TMR (NUM_TMR),
    .ADDR_W  (ADDR_W),
    .SLOT_AW (SLOT_AW)
  ) u_dec (
    .sel_i    (sel_i),
    .wr_i     (wr_i),
    .addr_i   (addr_i),
    .tmr_wr_o (tmr_wr),
    .idx_o    (idx),
    .hit_o    (hit),
    .rsel_o   (rsel)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    dt_timer_core #(
      .CNT_W    (CNT_W),
      .NARROW_W (NARROW_W)
    ) u_core (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .wr_i    (tmr_wr[g]),
      .rsel_i  (rsel),
      .wdata_i (wdata_i),
      .rdata_o (tmr_rd[g]),
      .irq_o   (tmr_irq[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (sel_i && hit && idx == IDX_W'(i)) rdata_o = tmr_rd[i];
    end
  end

  assign irq_o = |tmr_irq;

  // R2
  out_of_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !wr_i && addr_i >= ADDR_W'(WIN_TOP)) |-> (rdata_o == '0));

  // R11
  irq_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(sel_i && wr_i));
endmodule

// File: tb/tb_dual_timer.sv
module tb_dual_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b1;
  logic        sel_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  dual_timer dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .sel_i   (sel_i),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    sel_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    #1;
    sel_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic peek(input logic [11:0] a, output logic [31:0] v);
    sel_i = 1'b1; wr_i = 1'b0; addr_i = a;
    #1;
    v = rdata_o;
    sel_i = 1'b0;
  endtask

  // called right after a run-enabling write; returns the edge count of the first raw flag
  task automatic wait_fire(input logic [11:0] base, input int limit, input int probe_n,
                           output int n_fire, output logic [31:0] probe_cnt,
                           output logic [31:0] fire_cnt, output logic fire_irq);
    logic [31:0] v;
    n_fire = 0; probe_cnt = '0; fire_cnt = '0; fire_irq = 1'b0;
    for (int n = 1; n <= limit && n_fire == 0; n++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if (n == probe_n) peek(base + 12'h0C, probe_cnt);
      peek(base + 12'h14, v);
      if (v[0]) begin
        n_fire = n;
        fire_irq = irq_o;
        peek(base + 12'h0C, fire_cnt);
      end
    end
  endtask

  task automatic run_case(input int t, input int code, input int l);
    int d, nf;
    logic [31:0] pc, fc;
    logic fi;
    logic [11:0] base;
    d = (code == 1) ? 16 : (code == 2) ? 256 : 1;
    base = 12'(t * 32);
    wr(base + 12'h04, 32'(l));
    wr(base + 12'h10, 32'h0);
    wr(base, 32'h4B | 32'(code << 4));
    wait_fire(base, (l + 1) * d + 4, d, nf, pc, fc, fi);
    chk($sformatf("R5 fire edge t%0d code%0d L%0d", t, code, l), 32'(nf), 32'((l + 1) * d));
    if (l > 0) chk("R5 count after one prescaled tick", pc, 32'(l - 1));
    chk("R6 periodic reload at fire", fc, 32'(l));
    chk("R11 irq_o high on fire", {31'b0, fi}, 32'h1);
    wr(base, 32'h40);
    wr(base + 12'h10, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, pc, fc;
    int nf;
    logic fi;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    for (int t = 0; t < 2; t++) begin
      peek(12'(t * 32),        v); chk("R1 ctrl reset", v, 32'h40);
      peek(12'(t * 32) + 12'h04, v); chk("R1 reload reset", v, 32'h0);
      peek(12'(t * 32) + 12'h0C, v); chk("R1 count reset", v, 32'h0);
      peek(12'(t * 32) + 12'h14, v); chk("R1 raw reset", v, 32'h0);
      peek(12'(t * 32) + 12'h18, v); chk("R1 masked reset", v, 32'h0);
    end
    chk("R1 irq_o reset", {31'b0, irq_o}, 32'h0);

    // R4 R5 R6: both slots, every prescale code, several reloads
    for (int t = 0; t < 2; t++)
      for (int code = 0; code < 4; code++)
        for (int li = 0; li < 3; li++)
          run_case(t, code, (li == 2) ? 3 : li);

    // R13 prescaler phase restart
    wr(12'h004, 32'h1);
    wr(12'h000, 32'h53);
    repeat (7) @(posedge clk_i);
    wr(12'h000, 32'h53);
    wait_fire(12'h000, 40, 0, nf, pc, fc, fi);
    chk("R13 fire after ctrl rewrite", 32'(nf), 32'd32);
    wr(12'h000, 32'h40); wr(12'h010, 32'h0);

    // R7 free running, 16-bit then 32-bit
    wr(12'h020, 32'h40); wr(12'h024, 32'h2); wr(12'h020, 32'h41);
    wait_fire(12'h020, 8, 0, nf, pc, fc, fi);
    chk("R7 free16 fire edge", 32'(nf), 32'd3);
    chk("R7 free16 wrap value", fc, 32'h0000FFFF);
    wr(12'h020, 32'h48); wr(12'h030, 32'h0); wr(12'h024, 32'h2); wr(12'h020, 32'h49);
    wait_fire(12'h020, 8, 0, nf, pc, fc, fi);
    chk("R7 free32 wrap value", fc, 32'hFFFFFFFF);
    wr(12'h020, 32'h40); wr(12'h030, 32'h0);

    // R8 one-shot
    wr(12'h004, 32'h1); wr(12'h000, 32'h47);
    wait_fire(12'h000, 8, 0, nf, pc, fc, fi);
    chk("R8 oneshot fire edge", 32'(nf), 32'd2);
    chk("R8 oneshot count stays 0", fc, 32'h0);
    peek(12'h000, v); chk("R8 run bit cleared", v, 32'h46);
    repeat (5) @(posedge clk_i);
    @(negedge clk_i);
    peek(12'h00C, v); chk("R8 count still 0", v, 32'h0);
    wr(12'h000, 32'h40); wr(12'h010, 32'h0);

    // R10 masked vs raw
    wr(12'h024, 32'h0); wr(12'h020, 32'h03);
    wait_fire(12'h020, 4, 0, nf, pc, fc, fi);
    wr(12'h020, 32'h02);
    @(negedge clk_i);
    peek(12'h034, v); chk("R10 raw set with irq disabled", v, 32'h1);
    peek(12'h038, v); chk("R10 masked clear with irq disabled", v, 32'h0);
    chk("R11 irq_o low when masked", {31'b0, irq_o}, 32'h0);
    wr(12'h030, 32'h0);
    @(negedge clk_i);
    peek(12'h034, v); chk("R10 raw cleared by ack", v, 32'h0);
    wr(12'h020, 32'h40);

    // R11 merge of two pending flags
    wr(12'h004, 32'h0); wr(12'h024, 32'h0);
    wr(12'h000, 32'h43); wr(12'h020, 32'h43);
    wr(12'h000, 32'h40); wr(12'h020, 32'h40);
    @(negedge clk_i);
    chk("R11 irq_o both pending", {31'b0, irq_o}, 32'h1);
    wr(12'h010, 32'h0);
    @(negedge clk_i);
    peek(12'h014, v); chk("R11 timer0 raw cleared", v, 32'h0);
    chk("R11 irq_o held by timer1", {31'b0, irq_o}, 32'h1);
    wr(12'h030, 32'h0);
    @(negedge clk_i);
    chk("R11 irq_o low after both cleared", {31'b0, irq_o}, 32'h0);

    // R9 16-bit load mask; R3 count read-only
    wr(12'h004, 32'h12345);
    @(negedge clk_i);
    peek(12'h00C, v); chk("R9 narrow count masked", v, 32'h2345);
    peek(12'h004, v); chk("R9 reload keeps full word", v, 32'h12345);
    wr(12'h00C, 32'h777);
    @(negedge clk_i);
    peek(12'h00C, v); chk("R3 count write ignored", v, 32'h2345);
    peek(12'h01C, v); chk("R3 unused slot word reads 0", v, 32'h0);

    // R2 window edges
    peek(12'h040, v); chk("R2 read 0x40 zero", v, 32'h0);
    peek(12'hFFC, v); chk("R2 read 0xFFC zero", v, 32'h0);
    wr(12'h040, 32'h5B); wr(12'h060, 32'h5B); wr(12'h804, 32'h9);
    @(negedge clk_i);
    peek(12'h000, v); chk("R2 timer0 ctrl untouched", v, 32'h40);
    peek(12'h020, v); chk("R2 timer1 ctrl untouched", v, 32'h40);
    peek(12'h003, v); chk("R2 low addr bits ignored", v, 32'h40);

    // R12 background reload
    wr(12'h004, 32'h5); wr(12'h008, 32'h9);
    @(negedge clk_i);
    peek(12'h00C, v); chk("R12 bg reload keeps count", v, 32'h5);
    wr(12'h010, 32'h0); wr(12'h000, 32'h43);
    wait_fire(12'h000, 12, 0, nf, pc, fc, fi);
    chk("R12 fire from old count", 32'(nf), 32'd6);
    chk("R12 new reload used", fc, 32'h9);
    wr(12'h000, 32'h40); wr(12'h010, 32'h0);

    // R5 tick gating
    tick_i = 1'b0;
    wr(12'h024, 32'h5); wr(12'h020, 32'h4B);
    repeat (10) @(posedge clk_i);
    @(negedge clk_i);
    peek(12'h02C, v); chk("R5 count holds without tick", v, 32'h5);
    tick_i = 1'b1;
    wr(12'h020, 32'h40);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule